// File: doc/BRIEF.md
# Processor Status Register with Interrupt Admission

This block holds a 16-bit processor status word and decides, every clock, whether a pending interrupt is taken. The word carries two operating-system bits, a global interrupt enable, a 3-bit mask level and four arithmetic condition flags. The enable, mask and system bits are written by software through a byte-lane write port. The condition flags are loaded from the ALU through a separate update strobe. A return strobe restores the whole writable part of the word from a saved copy.

Two kinds of request reach the block. The first is a maskable request that carries a 3-bit priority, where 0 is the most urgent. The second is a non-maskable request. When a request is taken, the enable is cleared and the mask field is loaded with the level that was taken, both on the same clock edge. A one-cycle acceptance pulse and the taken level are then presented on the outputs. A maskable request nests only when software sets the enable again and the new request is strictly more urgent than the current mask.

Top module: `psw_intr_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000 and `acc_pulse` is 0.
- R2: Bits 15:14 and 7:4 always read 0. `sw_be[0]` enables writes to bits 7:0 and `sw_be[1]` enables writes to bits 15:8. Only bits 13:8 and 3:0 take written values.
- R3: When `flg_upd` is high, bits 3,2,1,0 load `flg_v`,`flg_c`,`flg_n`,`flg_z` in that order. All other bits keep their value.
- R4: A software write to the low byte in the same cycle as `flg_upd` wins over the flag update. A write to the high byte alone does not block the flag update.
- R5: A maskable request is taken only when the enable (bit 11) is 1 and `irq_lvl` is numerically lower than the mask field (bits 10:8). Otherwise nothing changes.
- R6: On taking a request, bit 11 is cleared and bits 10:8 are loaded with the taken level on that edge, and every other bit keeps its value. `acc_pulse` is high for that one cycle, with `acc_lvl` equal to the level.
- R7: `nmi_req` is taken whatever the enable and mask hold, and it wins over a simultaneous maskable request. It sets the mask field to 0 and reports level 0.
- R8: A request that stays high after being taken is not taken again. It must be low for at least one cycle before it can be taken again.
- R9: `reti` loads bits 13:8 and 3:0 from `reti_word` in one cycle, while reserved bits stay 0. It wins over a same-cycle software write.
- R10: When a request is taken in the same cycle as `reti`, the word takes the restored value, except that bit 11 is 0 and bits 10:8 hold the taken level. The admission decision uses the status word as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_we | input | 1 | Software write strobe |
| sw_be | input | 2 | Byte-lane enables for the write |
| sw_wdata | input | 16 | Software write data |
| rd_data | output | 16 | Current status word |
| flg_upd | input | 1 | Condition flag update strobe |
| flg_v | input | 1 | Signed overflow from the ALU |
| flg_c | input | 1 | Carry or borrow out of the MSB |
| flg_n | input | 1 | MSB of the result |
| flg_z | input | 1 | Result equals zero |
| irq_req | input | 1 | Maskable request pending |
| irq_lvl | input | 3 | Priority of the maskable request, 0 most urgent |
| nmi_req | input | 1 | Non-maskable request pending |
| reti | input | 1 | Return strobe, restores the saved word |
| reti_word | input | 16 | Saved status word to restore |
| acc_pulse | output | 1 | One-cycle pulse marking a taken request |
| acc_lvl | output | 3 | Level of the taken request |

## Verification
The bench targets the strict comparison at the mask boundary. A request whose level equals the mask must be held off, so a design that used less-or-equal would nest equal-priority work. It holds requests high after they are taken. A design without re-arming would pulse on every cycle, or would fire again as soon as software sets the enable. It also collides a low-byte write with a flag update, and a restore with an acceptance. A design with the wrong precedence would lose the written flags, or would leave the enable set after a request was taken.

// File: rtl/psw_pkg.sv
// Shared layout of the status word and the acceptance record.
// Assumes a 16-bit word split into byte lanes for software writes.
package psw_pkg;
    localparam int PSW_W     = 16;
    localparam int LVL_W     = 3;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = PSW_W / LANE_W;
    localparam int BIT_IE    = 11;
    localparam int IM_LO     = 8;
    localparam int IM_HI     = IM_LO + LVL_W - 1;
    localparam int FLG_W     = 4;
    localparam logic [PSW_W-1:0] WR_MASK = 16'h3F0F;

    typedef struct packed {
        logic             take;
        logic             is_nmi;
        logic [LVL_W-1:0] lvl;
    } grant_t;
endpackage

// File: rtl/psw_arbiter.sv
// Decides whether a pending request is taken this cycle and registers
// the acceptance pulse. Assumes ie/im are the registered status fields.
// Each source must be seen low once before it can be taken again.
module psw_arbiter
    import psw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_lvl,
    input  logic             nmi_req,
    input  logic             ie,
    input  logic [LVL_W-1:0] im,
    output grant_t           grant,
    output logic             acc_pulse,
    output logic [LVL_W-1:0] acc_lvl,
    output logic             acc_nmi
);
    logic nmi_armed_q;
    logic irq_armed_q;
    logic nmi_go;
    logic irq_go;

    // Admission decision: non-maskable first, then strict priority test.
    always_comb begin
        nmi_go       = nmi_req && nmi_armed_q;
        irq_go       = !nmi_go && irq_req && irq_armed_q && ie && (irq_lvl < im);
        grant.take   = nmi_go || irq_go;
        grant.is_nmi = nmi_go;
        grant.lvl    = nmi_go ? '0 : irq_lvl;
    end

    // Re-arm each source once it is seen low; disarm when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_armed_q <= 1'b1;
            irq_armed_q <= 1'b1;
        end else begin
            if (!nmi_req)    nmi_armed_q <= 1'b1;
            else if (nmi_go) nmi_armed_q <= 1'b0;
            if (!irq_req)    irq_armed_q <= 1'b1;
            else if (irq_go) irq_armed_q <= 1'b0;
        end
    end

    // Registered acceptance outputs, aligned with the updated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pulse <= 1'b0;
            acc_lvl   <= '0;
            acc_nmi   <= 1'b0;
        end else begin
            acc_pulse <= grant.take;
            acc_lvl   <= grant.take ? grant.lvl : '0;
            acc_nmi   <= grant.is_nmi;
        end
    end
endmodule

// File: rtl/psw_store.sv
// Status word register and its next-state merge. Assumes the precedence
// flags < software write < restore < acceptance (for IE and mask only).
module psw_store
    import psw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_we,
    input  logic [NUM_LANES-1:0] sw_be,
    input  logic [PSW_W-1:0]     sw_wdata,
    input  logic                 flg_upd,
    input  logic [FLG_W-1:0]     flg_in,
    input  logic                 reti,
    input  logic [PSW_W-1:0]     reti_word,
    input  grant_t               grant,
    output logic [PSW_W-1:0]     psw_q
);
    logic [PSW_W-1:0] after_flg;
    logic [PSW_W-1:0] after_sw;
    logic [PSW_W-1:0] nxt;

    // Stage 1: condition flags from the ALU.
    always_comb begin
        after_flg = psw_q;
        if (flg_upd) after_flg[FLG_W-1:0] = flg_in;
    end

    // Stage 2: per-lane software write overrides the flag stage.
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        assign after_sw[b*LANE_W +: LANE_W] = (sw_we && sw_be[b])
            ? sw_wdata[b*LANE_W +: LANE_W]
            : after_flg[b*LANE_W +: LANE_W];
    end

    // Stage 3: restore, then acceptance on enable/mask, then reserved mask.
    always_comb begin
        nxt = reti ? reti_word : after_sw;
        if (grant.take) begin
            nxt[BIT_IE]      = 1'b0;
            nxt[IM_HI:IM_LO] = grant.lvl;
        end
        nxt = nxt & WR_MASK;
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) psw_q <= '0;
        else        psw_q <= nxt;
    end
endmodule

// File: rtl/psw_intr_ctrl.sv
// Top: status word plus interrupt admission. The read port shows the
// registered word directly; acceptance outputs are registered.
module psw_intr_ctrl
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_we,
    input  logic [1:0]  sw_be,
    input  logic [15:0] sw_wdata,
    output logic [15:0] rd_data,
    input  logic        flg_upd,
    input  logic        flg_v,
    input  logic        flg_c,
    input  logic        flg_n,
    input  logic        flg_z,
    input  logic        irq_req,
    input  logic [2:0]  irq_lvl,
    input  logic        nmi_req,
    input  logic        reti,
    input  logic [15:0] reti_word,
    output logic        acc_pulse,
    output logic [2:0]  acc_lvl
);
    grant_t           grant;
    logic [PSW_W-1:0] psw_q;
    logic             acc_nmi;

    psw_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_lvl   (irq_lvl),
        .nmi_req   (nmi_req),
        .ie        (psw_q[BIT_IE]),
        .im        (psw_q[IM_HI:IM_LO]),
        .grant     (grant),
        .acc_pulse (acc_pulse),
        .acc_lvl   (acc_lvl),
        .acc_nmi   (acc_nmi)
    );

    psw_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (sw_we),
        .sw_be     (sw_be),
        .sw_wdata  (sw_wdata),
        .flg_upd   (flg_upd),
        .flg_in    ({flg_v, flg_c, flg_n, flg_z}),
        .reti      (reti),
        .reti_word (reti_word),
        .grant     (grant),
        .psw_q     (psw_q)
    );

    assign rd_data = psw_q;
endmodule

// File: rtl/psw_intr_ctrl_chk.sv
// Property checker attached to psw_intr_ctrl through bind.
module psw_intr_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rd_data,
    input logic        acc_pulse,
    input logic [2:0]  acc_lvl,
    input logic        acc_nmi
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:14] == 2'b00 && rd_data[7:4] == 4'h0);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 16'h0000 && !acc_pulse));

    assert_mask_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && !acc_nmi) |-> ($past(rd_data[11]) && acc_lvl < $past(rd_data[10:8])));

    assert_enable_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> (!rd_data[11] && rd_data[10:8] == acc_lvl));

    assert_nmi_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && acc_nmi) |-> (acc_lvl == 3'd0));
endmodule

bind psw_intr_ctrl psw_intr_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (rd_data),
    .acc_pulse (acc_pulse),
    .acc_lvl   (acc_lvl),
    .acc_nmi   (acc_nmi)
);

// File: tb/psw_intr_ctrl_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module psw_intr_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_be = 2'b00;
    logic [15:0] sw_wdata = '0;
    logic [15:0] rd_data;
    logic        flg_upd = 1'b0, flg_v = 1'b0, flg_c = 1'b0, flg_n = 1'b0, flg_z = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_lvl = '0;
    logic        nmi_req = 1'b0;
    logic        reti = 1'b0;
    logic [15:0] reti_word = '0;
    logic        acc_pulse;
    logic [2:0]  acc_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    psw_intr_ctrl dut_i (.*);

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One clock: inputs already driven; sample at the following negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sw_we = 0; sw_be = 0; flg_upd = 0; reti = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        sw_we = 1; sw_be = 2'b11; sw_wdata = d;
        tick();
        idle();
    endtask

    task automatic t_reset();
        check("R1 word", rd_data, 16'h0000);
        check("R1 pulse", {15'd0, acc_pulse}, 16'd0);
    endtask

    task automatic t_reserved();
        wr(16'hFFFF);
        check("R2 full write", rd_data, 16'h3F0F);
        sw_we = 1; sw_be = 2'b01; sw_wdata = 16'h0000;
        tick(); idle();
        check("R2 low lane only", rd_data, 16'h3F00);
    endtask

    task automatic t_flags();
        flg_upd = 1; {flg_v, flg_c, flg_n, flg_z} = 4'b1010;
        tick(); idle();
        check("R3 flag load", rd_data, 16'h3F0A);
        flg_upd = 1; {flg_v, flg_c, flg_n, flg_z} = 4'b1111;
        sw_we = 1; sw_be = 2'b01; sw_wdata = 16'hFF05;
        tick(); idle();
        check("R4 low write wins", rd_data, 16'h3F05);
        flg_upd = 1; {flg_v, flg_c, flg_n, flg_z} = 4'b0011;
        sw_we = 1; sw_be = 2'b10; sw_wdata = 16'h0000;
        tick(); idle();
        check("R4 high write keeps flags", rd_data, 16'h0003);
    endtask

    task automatic t_mask();
        wr(16'h0D05);
        irq_req = 1; irq_lvl = 3'd5;
        tick();
        check("R5 equal level held", {acc_pulse, rd_data[14:0]}, 16'h0D05);
        irq_lvl = 3'd6;
        tick();
        check("R5 lower level held", {acc_pulse, rd_data[14:0]}, 16'h0D05);
        irq_req = 0;
        wr(16'h0505);
        irq_req = 1; irq_lvl = 3'd2;
        tick();
        check("R5 disabled held", {acc_pulse, rd_data[14:0]}, 16'h0505);
        irq_req = 0;
        wr(16'h0D05);
        irq_req = 1; irq_lvl = 3'd4;
        tick();
        irq_req = 0;
        check("R6 word after take", rd_data, 16'h0405);
        check("R6 pulse", {13'd0, acc_pulse, 2'd0}, 16'h0004);
        check("R6 level", {13'd0, acc_lvl}, 16'h0004);
        tick();
        check("R6 single pulse", {15'd0, acc_pulse}, 16'd0);
    endtask

    task automatic t_nmi();
        wr(16'h0703);
        nmi_req = 1; irq_req = 1; irq_lvl = 3'd1;
        tick();
        check("R7 nmi word", rd_data, 16'h0003);
        check("R7 nmi pulse/level", {12'd0, acc_pulse, acc_lvl}, 16'h0008);
        irq_req = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R8 held nmi no retrigger", {15'd0, acc_pulse}, 16'd0);
        end
        nmi_req = 0;
        tick();
        nmi_req = 1;
        tick();
        check("R8 nmi rearmed", {15'd0, acc_pulse}, 16'd1);
        nmi_req = 0;
        tick();
    endtask

    task automatic t_irq_hold();
        wr(16'h0F00);
        irq_req = 1; irq_lvl = 3'd3;
        tick();
        check("R6 take level3", rd_data, 16'h0300);
        sw_we = 1; sw_be = 2'b11; sw_wdata = 16'h0F00;
        tick(); idle();
        check("R8 rewrite word", rd_data, 16'h0F00);
        tick();
        check("R8 held irq no retrigger", {acc_pulse, rd_data[14:0]}, 16'h0F00);
        irq_req = 0;
        tick();
        irq_req = 1;
        tick();
        irq_req = 0;
        check("R8 irq rearmed", {acc_pulse, rd_data[14:0]}, 16'h8300);
        tick();
    endtask

    task automatic t_reti();
        wr(16'h0000);
        reti = 1; reti_word = 16'hFFFF;
        sw_we = 1; sw_be = 2'b11; sw_wdata = 16'h0000;
        tick(); idle();
        check("R9 restore wins", rd_data, 16'h3F0F);
        wr(16'h0F00);
        reti = 1; reti_word = 16'h3A0C;
        irq_req = 1; irq_lvl = 3'd2;
        tick(); idle();
        irq_req = 0;
        check("R10 restore with take", rd_data, 16'h320C);
        check("R10 pulse level", {12'd0, acc_pulse, acc_lvl}, 16'h000A);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_reserved();
        t_flags();
        t_mask();
        t_nmi();
        t_irq_hold();
        t_reti();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule